// File: doc/BRIEF.md
# Signed multiply/divide unit with HI/LO result registers

This block is the multicycle arithmetic unit that sits beside an integer pipeline and executes the signed 32-bit multiply and divide instructions. A request is a one-cycle `start` pulse. It carries the R-type function code of the instruction and two 32-bit operands. The unit decodes the function code itself. Code 0x18 selects a multiply and code 0x1A selects a divide. Any other code makes no request. The unit then works through one result bit per clock. When it finishes, it writes its result into two architectural registers, HI and LO. Those registers drive the `hi` and `lo` read ports, which serve the move-from-HI and move-from-LO instructions.

A multiply leaves the full 64-bit product split across the pair: the upper word goes to HI and the lower word to LO. A divide puts the quotient in LO and the remainder in HI. Both operations work on magnitudes and restore the signs at the end. The quotient truncates toward zero, and the remainder follows the sign of the dividend. A divide by zero takes the normal time and leaves HI and LO as they were.

The request side is not a full valid/ready stream. `busy` plays the role of a deasserted ready. A `start` that arrives while `busy` is high is not held waiting: the unit drops it. Logic upstream must therefore issue a request only when `busy` is low. The control and status pins (`busy`, `done`) are plain levels.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `hi` and `lo` are both 0.
- R2: A request with function code 0x18 multiplies the operands as signed 32-bit values. On completion, `lo` holds bits 31..0 of the 64-bit product and `hi` holds bits 63..32.
- R3: A request with function code 0x1A divides `opa` by `opb` as signed values. On completion, `lo` holds the quotient and `hi` holds the remainder.
- R4: The quotient truncates toward zero, so it is negative when exactly one operand is negative. The remainder carries the sign of the dividend. The case -2^31 / -1 gives `lo` = 0x80000000 and `hi` = 0.
- R5: `busy` is high for exactly 33 consecutive cycles, starting with the cycle after the clock edge that accepts a request.
- R6: `done` is a single-cycle pulse in the cycle right after `busy` falls. In that cycle `hi` and `lo` already show the new result.
- R7: `done` rises 33 clock edges after the accepting edge, for both operations and for every operand value.
- R8: A divide with `opb` = 0 runs for the full time and pulses `done`, but leaves `hi` and `lo` unchanged.
- R9: A `start` pulse while `busy` is high is ignored. The running operation keeps its timing and its operands.
- R10: A `start` pulse with a function code other than 0x18 or 0x1A is ignored. `busy` stays low, and `hi` and `lo` do not change.
- R11: `hi` and `lo` change only at the clock edge that ends an operation. Between operations they hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| funct | input | 6 | R-type function code of the request |
| opa | input | 32 | First operand (multiplicand or dividend) |
| opb | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | Operation in progress; requests are dropped |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | HI register read port |
| lo | output | 32 | LO register read port |

## Verification
The bench builds the unit with its default 32-bit width. At that width the signed extremes are reachable: products of -2^31 with itself, -1 times -1, and the single overflowing quotient -2^31 / -1. The full 33-cycle latency is also observed at that width. A behavioural model in the bench tracks `busy`, `done`, `hi` and `lo` on every clock, using 64-bit integer arithmetic. Directed cases then stress the sign rules, a zero divisor, a request that collides with a running operation, and an unknown function code.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int XLEN    = 32;
  localparam int FUNCT_W = 6;

  localparam logic [FUNCT_W-1:0] FN_MULT = 6'h18;
  localparam logic [FUNCT_W-1:0] FN_DIV  = 6'h1A;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_e;
endpackage

// File: rtl/muldiv_mag.sv
module muldiv_mag #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] mag,
  output logic         neg
);
  always_comb begin
    neg = val[W-1];
    mag = neg ? (~val + 1'b1) : val;
  end
endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy,
  output logic step,
  output logic commit,
  output logic done
);
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  always_comb begin
    step   = busy_q && (cnt_q != LAST);
    commit = busy_q && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= commit;
      if (busy_q) begin
        if (commit) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + 1'b1;
      end else if (req) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R6: completion pulse lasts one cycle and follows the busy window
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R5: busy never drops before the last step
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> busy);
  // R9: a new request cannot rewind a running count
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0 && req) |=> (cnt_q != '0 || !busy));
endmodule

// File: rtl/muldiv_core.sv
module muldiv_core
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  md_op_e       op_in,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  input  logic         neg_a,
  input  logic         neg_b,
  input  logic         zero_b,
  output md_op_e       op,
  output logic         div0,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  md_op_e       op_q;
  logic         qneg_q;
  logic         rneg_q;
  logic         div0_q;
  logic [W-1:0] b_q;
  logic [W-1:0] acc_hi_q;
  logic [W-1:0] acc_lo_q;

  logic [W:0]   sum;
  logic [W:0]   shl;
  logic [W:0]   diff;
  logic         ge;

  always_comb begin
    sum  = acc_lo_q[0] ? ({1'b0, acc_hi_q} + {1'b0, b_q}) : {1'b0, acc_hi_q};
    shl  = {acc_hi_q, acc_lo_q[W-1]};
    diff = shl - {1'b0, b_q};
    ge   = !diff[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_MUL;
      qneg_q   <= 1'b0;
      rneg_q   <= 1'b0;
      div0_q   <= 1'b0;
      b_q      <= '0;
      acc_hi_q <= '0;
      acc_lo_q <= '0;
    end else if (load) begin
      op_q     <= op_in;
      qneg_q   <= neg_a ^ neg_b;
      rneg_q   <= neg_a;
      div0_q   <= zero_b;
      b_q      <= mag_b;
      acc_hi_q <= '0;
      acc_lo_q <= mag_a;
    end else if (step) begin
      if (op_q == OP_MUL) begin
        acc_hi_q <= sum[W:1];
        acc_lo_q <= {sum[0], acc_lo_q[W-1:1]};
      end else begin
        acc_hi_q <= ge ? diff[W-1:0] : shl[W-1:0];
        acc_lo_q <= {acc_lo_q[W-2:0], ge};
      end
    end
  end

  muldiv_fixup #(.W(W)) u_fixup (
    .is_div (op_q == OP_DIV),
    .qneg   (qneg_q),
    .rneg   (rneg_q),
    .raw_hi (acc_hi_q),
    .raw_lo (acc_lo_q),
    .res_hi (res_hi),
    .res_lo (res_lo)
  );

  assign op   = op_q;
  assign div0 = div0_q;

  // R9: captured operands stay put while the iteration runs
  p_operand_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ($stable(b_q) && $stable(op_q)));
endmodule

// File: rtl/muldiv_fixup.sv
module muldiv_fixup #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic         qneg,
  input  logic         rneg,
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  logic [2*W-1:0] prod;
  logic [2*W-1:0] prod_s;

  always_comb begin
    prod   = {raw_hi, raw_lo};
    prod_s = qneg ? (~prod + 1'b1) : prod;
    if (is_div) begin
      res_lo = qneg ? (~raw_lo + 1'b1) : raw_lo;
      res_hi = rneg ? (~raw_hi + 1'b1) : raw_hi;
    end else begin
      res_lo = prod_s[W-1:0];
      res_hi = prod_s[2*W-1:W];
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FUNCT_W-1:0] funct,
  input  logic [W-1:0]       opa,
  input  logic [W-1:0]       opb,
  output logic               busy,
  output logic               done,
  output logic [W-1:0]       hi,
  output logic [W-1:0]       lo
);
  localparam int STEPS = W;

  logic         is_mul, is_div, known, req;
  logic         step, commit;
  md_op_e       op_run;
  logic         div0_run;
  logic [W-1:0] res_hi, res_lo;
  logic [W-1:0] hi_q, lo_q;

  logic [W-1:0] opnd [2];
  logic [W-1:0] mag  [2];
  logic         neg  [2];

  always_comb begin
    is_mul = (funct == FN_MULT);
    is_div = (funct == FN_DIV);
    known  = is_mul || is_div;
    req    = start && known;
    opnd[0] = opa;
    opnd[1] = opb;
  end

  for (genvar g = 0; g < 2; g++) begin : g_mag
    muldiv_mag #(.W(W)) u_mag (
      .val (opnd[g]),
      .mag (mag[g]),
      .neg (neg[g])
    );
  end

  muldiv_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .busy   (busy),
    .step   (step),
    .commit (commit),
    .done   (done)
  );

  muldiv_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (req && !busy),
    .step   (step),
    .op_in  (is_div ? OP_DIV : OP_MUL),
    .mag_a  (mag[0]),
    .mag_b  (mag[1]),
    .neg_a  (neg[0]),
    .neg_b  (neg[1]),
    .zero_b (opb == '0),
    .op     (op_run),
    .div0   (div0_run),
    .res_hi (res_hi),
    .res_lo (res_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (commit && !(op_run == OP_DIV && div0_run)) begin
      hi_q <= res_hi;
      lo_q <= res_lo;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  // R11: the pair moves only on a completing edge
  p_hilo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(hi_q) && $stable(lo_q)));
  // R8: a zero divisor leaves the pair untouched
  p_div0_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op_run == OP_DIV && div0_run) |=> ($stable(hi_q) && $stable(lo_q)));
  // R10: unknown function codes never start the unit
  p_bad_funct_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !known) |=> !busy);
endmodule

// File: tb/muldiv_hilo_bench.sv
module muldiv_hilo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  funct = 6'h00;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int tests = 0;
  int fails = 0;
  int cyc_total = 0;
  bit cmp_en = 1'b0;

  // reference model state
  bit          m_busy = 1'b0, m_done = 1'b0;
  int          m_left = 0;
  logic [31:0] m_hi = '0, m_lo = '0, m_phi = '0, m_plo = '0;
  bit          m_pwr = 1'b0;
  // tracked architectural values for directed checks
  logic [31:0] t_hi = '0, t_lo = '0;

  always #5 clk = ~clk;

  muldiv_hilo u_muldiv_hilo (
    .clk(clk), .rst_n(rst_n), .start(start), .funct(funct),
    .opa(opa), .opb(opb), .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  function automatic void ref_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                                 output bit wr, output logic [31:0] rh, output logic [31:0] rl);
    longint la, lb, p, q, r;
    la = longint'($signed(a));
    lb = longint'($signed(b));
    wr = 1'b1; rh = '0; rl = '0;
    if (f == 6'h18) begin
      p  = la * lb;
      rh = p[63:32];
      rl = p[31:0];
    end else if (b == 32'd0) begin
      wr = 1'b0;
    end else begin
      q  = la / lb;
      r  = la % lb;
      rh = r[31:0];
      rl = q[31:0];
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // model: one update per clock edge
  always @(posedge clk) begin
    cyc_total++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_hi = '0; m_lo = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_done = 1;
          if (m_pwr) begin m_hi = m_phi; m_lo = m_plo; end
        end
      end else if (start && (funct == 6'h18 || funct == 6'h1A)) begin
        m_busy = 1;
        m_left = 33;
        ref_op(funct, opa, opb, m_pwr, m_phi, m_plo);
      end
    end
    if (cyc_total > 150000) begin
      chk(1'b0, "R7", "watchdog expired", cyc_total, 150000);
      finish_run();
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(busy == m_busy, "R5", "busy vs model", busy, m_busy);
      chk(done == m_done, "R6", "done vs model", done, m_done);
      chk(hi == m_hi, "R11", "hi vs model", hi, m_hi);
      chk(lo == m_lo, "R11", "lo vs model", lo, m_lo);
    end
  end

  // issue one request; optionally collide a second request at cycle `hit`
  task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                        input string req, input int hit = -1);
    bit wr;
    logic [31:0] eh, el;
    int cyc;
    ref_op(f, a, b, wr, eh, el);
    if (wr) begin t_hi = eh; t_lo = el; end
    @(negedge clk);
    start = 1'b1; funct = f; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (cyc == hit) begin
        start = 1'b1; funct = 6'h1A; opa = 32'd999; opb = 32'd3;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(cyc == 33, "R7", "done latency", cyc, 33);
    chk(hi == t_hi, req, "hi result", hi, t_hi);
    chk(lo == t_lo, req, "lo result", lo, t_lo);
    @(negedge clk);
    chk(!done, "R6", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
    chk(hi == 0 && lo == 0, "R1", "hi/lo in reset", {hi, lo}, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    chk(!busy && hi == 0 && lo == 0, "R1", "state after reset release", {busy, hi, lo}, 0);

    // R2 multiply
    run_op(6'h18, 32'd7, 32'd6, "R2");
    run_op(6'h18, 32'hFFFF_FFFD, 32'd5, "R2");
    run_op(6'h18, 32'h8000_0000, 32'h8000_0000, "R2");
    run_op(6'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    run_op(6'h18, 32'h1234_5678, 32'h9ABC_DEF0, "R2");

    // R3 / R4 divide and sign rules
    run_op(6'h1A, 32'd100, 32'd7, "R3");
    run_op(6'h1A, 32'd3, 32'd10, "R3");
    run_op(6'h1A, -32'sd100, 32'd7, "R4");
    run_op(6'h1A, 32'd100, -32'sd7, "R4");
    run_op(6'h1A, -32'sd100, -32'sd7, "R4");
    run_op(6'h1A, 32'h8000_0000, 32'hFFFF_FFFF, "R4");

    // R8 divide by zero keeps HI/LO
    run_op(6'h1A, 32'd55, 32'd0, "R8");

    // R9 collision: second request dropped, first result survives
    run_op(6'h18, 32'd1000, 32'd3000, "R9", 5);
    run_op(6'h18, 32'hDEAD_BEEF, 32'd17, "R9", 32);

    // R10 unknown function code
    @(negedge clk);
    start = 1'b1; funct = 6'h20; opa = 32'd9; opb = 32'd9;
    @(negedge clk);
    start = 1'b0;
    chk(!busy, "R10", "busy after unknown funct", busy, 0);
    repeat (3) @(negedge clk);
    chk(hi == t_hi && lo == t_lo, "R10", "hi/lo after unknown funct", {hi, lo}, {t_hi, t_lo});

    // R11 values persist while idle
    repeat (10) @(negedge clk);
    chk(hi == t_hi && lo == t_lo, "R11", "hi/lo idle hold", {hi, lo}, {t_hi, t_lo});

    cmp_en = 1'b0;
    finish_run();
  end
endmodule